// File: doc/BRIEF.md
# Strong Luma Edge Filter

This block applies the strong smoothing filter across a vertical block edge for a group of four luma lines processed in parallel. Each line supplies four samples on the left side of the edge (index 0 nearest the edge, index 3 farthest) and four on the right side, numbered the same way. On each side the three samples nearest the edge are replaced by weighted averages that span the edge. The sample farthest from the edge is never changed.

Each filtered sample is limited to a window of plus or minus twice the clipping threshold `tc_i` around its original value. That window saturates at 0 and at the maximum sample value. A per-side enable selects whether that side is written. A disabled side passes its original samples through, and its write mask stays low.

The deciding logic sits upstream and chooses the strong filter and looks up `tc_i`. Results are registered and appear one clock after `valid_i`, together with `valid_o` and the two write masks.

Top module: `slf_strong_luma`

## Requirements
- R1: With the left enable set, left output index 0 of each line equals clamp((L2 + 2*L1 + 2*L0 + 2*R0 + R1 + 4) >> 3). Ln is left input index n and Rn is right input index n.
- R2: With the left enable set, left output index 1 equals clamp((L2 + L1 + L0 + R0 + 2) >> 2).
- R3: With the left enable set, left output index 2 equals clamp((2*L3 + 3*L2 + L1 + L0 + R0 + 4) >> 3).
- R4: With the right enable set, right outputs 0..2 follow R1..R3 with the roles of the left and right samples swapped.
- R5: The clamp keeps each filtered value inside [orig - 2*tc, orig + 2*tc]. With tc = 0 every enabled sample keeps its original value.
- R6: The clamp window is saturated to [0, 255]. A lower bound below 0 becomes 0, and an upper bound above 255 becomes 255.
- R7: When a side's enable is clear, all four of its outputs equal its inputs. The write mask of each side is the enable that was registered with a valid input.
- R8: Index 3 on each side is always output unchanged.
- R9: `valid_o` is `valid_i` delayed by exactly one clock.
- R10: The lines are filtered independently. Each line's outputs depend only on that line's inputs and on `tc_i`.
- R11: After reset, all sample outputs, both masks and `valid_o` are 0.
- R12: In a cycle where `valid_i` is low, the sample outputs hold their previous values, and `valid_o` and both masks go low.

Port packing: sample n of line l occupies bits [(l*4+n)*8 +: 8].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Input group valid |
| tc_i | input | 7 | Clipping threshold |
| en_p_i | input | 1 | Left-side write enable |
| en_q_i | input | 1 | Right-side write enable |
| p_i | input | 128 | Left samples, 4 lines x 4 taps x 8 bits |
| q_i | input | 128 | Right samples, 4 lines x 4 taps x 8 bits |
| valid_o | output | 1 | Output group valid |
| wmask_p_o | output | 1 | Left-side write mask |
| wmask_q_o | output | 1 | Right-side write mask |
| p_o | output | 128 | Filtered left samples |
| q_o | output | 128 | Filtered right samples |

## Verification
The sweep walks `tc_i` from 0 upward while mixing random, ramped, stepped and full-swing 0/255 sample patterns, and it cycles through all four enable combinations.

Full-swing steps with a large `tc_i` drive the clamp window against both rails. A design that computed the bounds without saturation would wrap around there and emit values near the wrong rail.

A `tc_i` of 0 must freeze every sample. An off-by-one in the clamp or a clamp applied only to the upper bound would let the raw average through. An intermediate sum that is too narrow truncates the weighted sums near 255 and produces dark outliers.

Idle cycles with scrambled inputs expose outputs that fail to hold. Side enables that are swapped or ignored show up as changed samples on a side that should pass through.

// File: rtl/slf_pkg.sv
package slf_pkg;
  localparam int TAPS = 4;

  // true when val lies within orig +/- 2*tc
  function automatic logic in_reach(int orig, int val, int tc);
    int d;
    d = (val > orig) ? val - orig : orig - val;
    return d <= 2 * tc;
  endfunction
endpackage

// File: rtl/slf_clamp.sv
module slf_clamp #(
  parameter int PIX_W = 8,
  parameter int TC_W  = 7
) (
  input  logic [PIX_W-1:0] orig_i,
  input  logic [PIX_W-1:0] raw_i,
  input  logic [TC_W-1:0]  tc_i,
  output logic [PIX_W-1:0] out_o
);
  localparam int W = ((PIX_W > TC_W + 1) ? PIX_W : TC_W + 1) + 2;
  localparam logic [W-1:0] MAXV = W'((1 << PIX_W) - 1);

  logic [W-1:0] reach, up, lo, hi, raw_w;

  always_comb begin
    reach = W'(tc_i) << 1;
    up    = W'(orig_i) + reach;
    hi    = (up > MAXV) ? MAXV : up;
    lo    = (reach > W'(orig_i)) ? '0 : W'(orig_i) - reach;
    raw_w = W'(raw_i);
    if (raw_w < lo)      out_o = lo[PIX_W-1:0];
    else if (raw_w > hi) out_o = hi[PIX_W-1:0];
    else                 out_o = raw_i;
  end
endmodule

// File: rtl/slf_side.sv
module slf_side #(
  parameter int PIX_W = 8,
  parameter int TC_W  = 7
) (
  input  logic [3:0][PIX_W-1:0] own_i,
  input  logic [1:0][PIX_W-1:0] oth_i,
  input  logic [TC_W-1:0]       tc_i,
  output logic [2:0][PIX_W-1:0] flt_o
);
  localparam int SUM_W = PIX_W + 3;

  logic [SUM_W-1:0] s0, s1, s2;
  logic [2:0][PIX_W-1:0] raw;

  always_comb begin
    s0 = SUM_W'(own_i[2]) + (SUM_W'(own_i[1]) << 1) + (SUM_W'(own_i[0]) << 1)
       + (SUM_W'(oth_i[0]) << 1) + SUM_W'(oth_i[1]) + SUM_W'(4);
    s1 = SUM_W'(own_i[2]) + SUM_W'(own_i[1]) + SUM_W'(own_i[0])
       + SUM_W'(oth_i[0]) + SUM_W'(2);
    s2 = (SUM_W'(own_i[3]) << 1) + SUM_W'(3) * SUM_W'(own_i[2]) + SUM_W'(own_i[1])
       + SUM_W'(own_i[0]) + SUM_W'(oth_i[0]) + SUM_W'(4);
    raw[0] = s0[PIX_W+2:3];
    raw[1] = s1[PIX_W+1:2];
    raw[2] = s2[PIX_W+2:3];
  end

  for (genvar k = 0; k < 3; k++) begin : g_tap
    slf_clamp #(.PIX_W(PIX_W), .TC_W(TC_W)) u_clamp (
      .orig_i(own_i[k]),
      .raw_i (raw[k]),
      .tc_i  (tc_i),
      .out_o (flt_o[k])
    );
  end
endmodule

// File: rtl/slf_strong_luma.sv
module slf_strong_luma #(
  parameter int LINES = 4,
  parameter int PIX_W = 8,
  parameter int TC_W  = 7
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           valid_i,
  input  logic [TC_W-1:0]                tc_i,
  input  logic                           en_p_i,
  input  logic                           en_q_i,
  input  logic [LINES*4*PIX_W-1:0]       p_i,
  input  logic [LINES*4*PIX_W-1:0]       q_i,
  output logic                           valid_o,
  output logic                           wmask_p_o,
  output logic                           wmask_q_o,
  output logic [LINES*4*PIX_W-1:0]       p_o,
  output logic [LINES*4*PIX_W-1:0]       q_o
);
  localparam int LN_W  = slf_pkg::TAPS * PIX_W;
  localparam int VEC_W = LINES * LN_W;

  logic [VEC_W-1:0] p_nxt, q_nxt;

  for (genvar l = 0; l < LINES; l++) begin : g_line
    logic [3:0][PIX_W-1:0] p_ln, q_ln;
    logic [2:0][PIX_W-1:0] p_flt, q_flt;

    assign p_ln = p_i[l*LN_W +: LN_W];
    assign q_ln = q_i[l*LN_W +: LN_W];

    slf_side #(.PIX_W(PIX_W), .TC_W(TC_W)) u_p (
      .own_i(p_ln), .oth_i(q_ln[1:0]), .tc_i(tc_i), .flt_o(p_flt)
    );
    slf_side #(.PIX_W(PIX_W), .TC_W(TC_W)) u_q (
      .own_i(q_ln), .oth_i(p_ln[1:0]), .tc_i(tc_i), .flt_o(q_flt)
    );

    assign p_nxt[l*LN_W +: LN_W] = en_p_i ? {p_ln[3], p_flt} : p_ln;
    assign q_nxt[l*LN_W +: LN_W] = en_q_i ? {q_ln[3], q_flt} : q_ln;

    // far tap never touched
    AST_P3_KEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
      valid_i |=> p_o[l*LN_W + 3*PIX_W +: PIX_W] == $past(p_i[l*LN_W + 3*PIX_W +: PIX_W])); // R8
    AST_Q3_KEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
      valid_i |=> q_o[l*LN_W + 3*PIX_W +: PIX_W] == $past(q_i[l*LN_W + 3*PIX_W +: PIX_W])); // R8
    AST_P_OFF_KEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (valid_i && !en_p_i) |=> p_o[l*LN_W +: LN_W] == $past(p_i[l*LN_W +: LN_W])); // R7
    AST_Q_OFF_KEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (valid_i && !en_q_i) |=> q_o[l*LN_W +: LN_W] == $past(q_i[l*LN_W +: LN_W])); // R7

    for (genvar k = 0; k < 3; k++) begin : g_reach
      AST_P_REACH: assert property (@(posedge clk_i) disable iff (!rst_ni)
        valid_i |=> slf_pkg::in_reach(int'($past(p_i[l*LN_W + k*PIX_W +: PIX_W])),
                                      int'(p_o[l*LN_W + k*PIX_W +: PIX_W]),
                                      int'($past(tc_i)))); // R5
      AST_Q_REACH: assert property (@(posedge clk_i) disable iff (!rst_ni)
        valid_i |=> slf_pkg::in_reach(int'($past(q_i[l*LN_W + k*PIX_W +: PIX_W])),
                                      int'(q_o[l*LN_W + k*PIX_W +: PIX_W]),
                                      int'($past(tc_i)))); // R5
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o   <= 1'b0;
      wmask_p_o <= 1'b0;
      wmask_q_o <= 1'b0;
      p_o       <= '0;
      q_o       <= '0;
    end else begin
      valid_o   <= valid_i;
      wmask_p_o <= valid_i & en_p_i;
      wmask_q_o <= valid_i & en_q_i;
      if (valid_i) begin
        p_o <= p_nxt;
        q_o <= q_nxt;
      end
    end
  end

  AST_VALID_LAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o); // R9
  AST_VALID_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o); // R9
  AST_MASK_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wmask_p_o || wmask_q_o) |-> valid_o); // R7
  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> ($stable(p_o) && $stable(q_o))); // R12
endmodule

// File: tb/sim_slf_strong_luma.sv
module sim_slf_strong_luma;
  localparam int LINES = 4;
  localparam int VW = LINES * 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic valid_i = 1'b0, en_p = 1'b0, en_q = 1'b0;
  logic [6:0] tc = '0;
  logic [VW-1:0] p_i = '0, q_i = '0;
  logic valid_o, wm_p, wm_q;
  logic [VW-1:0] p_o, q_o;

  int n_chk = 0, n_err = 0;
  bit done = 0;
  int unsigned seed = 32'h1234_5678;
  int pv[LINES][4], qv[LINES][4];
  int ep[LINES][4], eq[LINES][4];
  int exp_mp, exp_mq;

  always #5 clk = ~clk;

  slf_strong_luma u0 (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid_i), .tc_i(tc),
    .en_p_i(en_p), .en_q_i(en_q), .p_i(p_i), .q_i(q_i),
    .valid_o(valid_o), .wmask_p_o(wm_p), .wmask_q_o(wm_q), .p_o(p_o), .q_o(q_o)
  );

  function automatic int rnd8();
    seed = seed * 32'd1103515245 + 32'd12345;
    return int'((seed >> 16) & 32'hff);
  endfunction

  function automatic int clampb(int f, int o, int t);
    int lo, hi;
    lo = o - 2 * t; if (lo < 0) lo = 0;
    hi = o + 2 * t; if (hi > 255) hi = 255;
    return (f < lo) ? lo : (f > hi) ? hi : f;
  endfunction

  function automatic int tap_ref(int k, int a3, int a2, int a1, int a0, int b0, int b1);
    if (k == 0) return (a2 + 2*a1 + 2*a0 + 2*b0 + b1 + 4) >> 3;
    if (k == 1) return (a2 + a1 + a0 + b0 + 2) >> 2;
    return (2*a3 + 3*a2 + a1 + a0 + b0 + 4) >> 3;
  endfunction

  task automatic chk(string tag, int act, int expv, string what);
    n_chk++;
    if (act != expv) begin
      n_err++;
      $display("FAIL %s %s act %0d exp %0d", tag, what, act, expv);
    end
  endtask

  task automatic pack_in();
    for (int l = 0; l < LINES; l++)
      for (int k = 0; k < 4; k++) begin
        p_i[(l*4+k)*8 +: 8] = 8'(pv[l][k]);
        q_i[(l*4+k)*8 +: 8] = 8'(qv[l][k]);
      end
  endtask

  task automatic compute_exp(int t, bit ep_en, bit eq_en);
    for (int l = 0; l < LINES; l++)
      for (int k = 0; k < 4; k++) begin
        ep[l][k] = (ep_en && k < 3) ?
          clampb(tap_ref(k, pv[l][3], pv[l][2], pv[l][1], pv[l][0], qv[l][0], qv[l][1]), pv[l][k], t) : pv[l][k];
        eq[l][k] = (eq_en && k < 3) ?
          clampb(tap_ref(k, qv[l][3], qv[l][2], qv[l][1], qv[l][0], pv[l][0], pv[l][1]), qv[l][k], t) : qv[l][k];
      end
  endtask

  // runs one valid group and checks it; tag_ovr overrides the tag when non-empty
  task automatic run_vec(int t, bit e_p, bit e_q, string tag_ovr);
    string tg, w;
    tc = 7'(t); en_p = e_p; en_q = e_q; valid_i = 1'b1;
    pack_in();
    compute_exp(t, e_p, e_q);
    @(negedge clk);
    chk("R9", int'(valid_o), 1, "valid_o");
    chk("R7", int'(wm_p), int'(e_p), "wmask_p");
    chk("R7", int'(wm_q), int'(e_q), "wmask_q");
    for (int l = 0; l < LINES; l++)
      for (int k = 0; k < 4; k++) begin
        for (int s = 0; s < 2; s++) begin
          int act, o;
          bit en;
          act = s ? int'(q_o[(l*4+k)*8 +: 8]) : int'(p_o[(l*4+k)*8 +: 8]);
          o   = s ? qv[l][k] : pv[l][k];
          en  = s ? e_q : e_p;
          if (tag_ovr != "") tg = tag_ovr;
          else if (k == 3) tg = "R8";
          else if (!en) tg = "R7";
          else if (o - 2*t < 0 || o + 2*t > 255) tg = "R6";
          else if (s == 1) tg = "R4";
          else tg = (k == 0) ? "R1" : (k == 1) ? "R2" : "R3";
          w = $sformatf("line %0d %s%0d", l, s ? "right" : "left", k);
          chk(tg, act, s ? eq[l][k] : ep[l][k], w);
          if (en && k < 3) begin
            int d;
            d = (act > o) ? act - o : o - act;
            chk("R5", int'(d <= 2*t), 1, {w, " reach"});
          end
        end
      end
  endtask

  task automatic idle_check();
    valid_i = 1'b0; en_p = 1'b1; en_q = 1'b1; tc = 7'd50;
    p_i = {4{32'hdead_beef}}; q_i = {4{32'h0bad_cafe}};
    @(negedge clk);
    chk("R12", int'(valid_o), 0, "valid_o idle");
    chk("R12", int'(wm_p | wm_q), 0, "masks idle");
    for (int l = 0; l < LINES; l++)
      for (int k = 0; k < 4; k++) begin
        chk("R12", int'(p_o[(l*4+k)*8 +: 8]), ep[l][k], "left hold");
        chk("R12", int'(q_o[(l*4+k)*8 +: 8]), eq[l][k], "right hold");
      end
  endtask

  task automatic fill(int mode);
    int a, b;
    a = rnd8(); b = rnd8();
    for (int l = 0; l < LINES; l++)
      for (int k = 0; k < 4; k++) begin
        case (mode)
          0: begin pv[l][k] = rnd8(); qv[l][k] = rnd8(); end
          1: begin pv[l][k] = (a + (rnd8() & 7)) & 255; qv[l][k] = (a + (rnd8() & 7)) & 255; end
          2: begin pv[l][k] = a; qv[l][k] = b; end
          default: begin pv[l][k] = (rnd8() & 1) ? 255 : 0; qv[l][k] = (rnd8() & 1) ? 255 : 0; end
        endcase
      end
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  endtask

  initial begin
    #2000000;
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11: reset state
    chk("R11", int'(valid_o), 0, "valid_o reset");
    chk("R11", int'(wm_p | wm_q), 0, "masks reset");
    chk("R11", int'(p_o == '0 && q_o == '0), 1, "samples reset");
    rst_n = 1'b1;
    @(negedge clk);

    // R6: full-swing step with large tc drives the window to the rails
    for (int l = 0; l < LINES; l++)
      for (int k = 0; k < 4; k++) begin pv[l][k] = 0; qv[l][k] = 255; end
    run_vec(100, 1, 1, "R6");
    // R5: tc of zero freezes everything
    run_vec(0, 1, 1, "R5");
    // R10: each line distinct
    for (int l = 0; l < LINES; l++)
      for (int k = 0; k < 4; k++) begin pv[l][k] = 40*l + 3*k; qv[l][k] = 200 - 30*l - 5*k; end
    run_vec(24, 1, 1, "R10");
    idle_check();

    for (int i = 0; i < 2000; i++) begin
      fill(i % 4);
      run_vec((i / 4) % 64, 1'((i >> 1) & 1), 1'(i & 1) ^ 1'((i >> 3) & 1), "");
      if (i % 7 == 6) idle_check();
    end
    done = 1;
    finish_run();
  end
endmodule